// File: doc/BRIEF.md
# Register Rename Map Table

This block is the rename table for one register class of an out-of-order core. It holds one physical register tag per architectural register index. The front end reads current mappings through a combinational lookup port. It allocates a fresh mapping through a rename port, which takes the oldest tag from a free-list FIFO inside the block. On a squash, a direct set-entry port writes an older tag back into one entry.

A rename reports two tags: the newly installed one and the one it displaced. The displaced tag can then be tracked for later release. One architectural index may be configured as a hard-wired zero register. Renames of that index change nothing and consume no tag. The free list's occupancy is visible at the ports, and a rename that finds it empty is refused with a stall.

Top module: `rename_map_table`

## Requirements
- R1: After reset, architectural register i maps to tag i for every i below NUM_ARCH. The free list holds tags NUM_ARCH up to NUM_PHYS-1, handed out in ascending order, and `free_count` equals NUM_PHYS-NUM_ARCH.
- R2: A rename request with an in-range, non-zero index and a non-empty free list does four things in its cycle. It raises `rn_done`, drives the oldest free tag on `rn_new_tag`, and drives the entry's current tag on `rn_old_tag`. From the next cycle, the entry holds the new tag and `free_count` is one lower.
- R3: A rename of index ZERO_IDX raises `rn_done` with `rn_new_tag` and `rn_old_tag` both equal to the current mapping. The table and `free_count` stay unchanged.
- R4: When ZERO_IDX is not below NUM_ARCH, no index is treated as a zero register, and index 0 renames like any other.
- R5: A set-entry write (`set_en`) stores `set_tag` into entry `set_idx` from the next cycle. It leaves `free_count` unchanged.
- R6: `lk_tag` combinationally returns the tag stored for `lk_idx`. A rename of the same index in the same cycle is not seen until the next cycle.
- R7: A rename request with an in-range, non-zero index while `free_count` is 0 raises `rn_stall`, keeps `rn_done` low, and changes neither the table nor the count.
- R8: An index at or above NUM_ARCH on any port raises `idx_err` in that cycle, and the operation has no effect. In that case the lookup returns 0, and a rename neither completes nor stalls.
- R9: When a set-entry write and a rename target the same index in one cycle, the set tag is the one stored. The rename still pops its tag and reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_idx | input | IDX_W | Lookup architectural index |
| lk_tag | output | TAG_W | Tag currently mapped to `lk_idx` (0 if out of range) |
| rn_req | input | 1 | Rename request |
| rn_idx | input | IDX_W | Architectural index to rename |
| rn_done | output | 1 | Rename accepted this cycle |
| rn_stall | output | 1 | Rename refused, free list empty |
| rn_new_tag | output | TAG_W | Tag installed by the rename |
| rn_old_tag | output | TAG_W | Tag displaced by the rename |
| set_en | input | 1 | Direct entry write (squash rollback) |
| set_idx | input | IDX_W | Entry to overwrite |
| set_tag | input | TAG_W | Tag to store |
| free_count | output | CNT_W | Number of tags left in the free list |
| idx_err | output | 1 | Some port carries an out-of-range index |

## Verification
The assertions assume that reset is held for at least one clock edge before any request. They also assume that `set_tag` values are legal tags below NUM_PHYS. The stimulus drives every input only at the falling edge, holds reset low from time zero, and restores only tags that the table once held. The out-of-range cases use indices above NUM_ARCH but within the index width, so the error path is exercised without any undefined value.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

   // Outcome of the rename port in the current cycle
   typedef enum logic [2:0] {
      RN_IDLE  = 3'd0,
      RN_DONE  = 3'd1,
      RN_ZERO  = 3'd2,
      RN_STALL = 3'd3,
      RN_ERR   = 3'd4
   } rn_outcome_e;

endpackage

// File: rtl/rmt_free_list.sv
module rmt_free_list #(
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 16,
   localparam int DEPTH = NUM_PHYS - NUM_ARCH,
   localparam int TAG_W = $clog2(NUM_PHYS),
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop,
   output logic [TAG_W-1:0] head_tag,
   output logic [CNT_W-1:0] count,
   output logic             empty
);

   logic [TAG_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0] rd_ptr;

   // Tags absent from the reset mapping fill the FIFO in ascending order
   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) slot[k] <= TAG_W'(NUM_ARCH + k);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         count  <= CNT_W'(DEPTH);
      end else if (pop) begin
         rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
         count  <= count - CNT_W'(1);
      end
   end

   assign head_tag = slot[rd_ptr];
   assign empty    = (count == '0);

   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));

   assert_pop_decrements_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (count == $past(count) - CNT_W'(1)));

   assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pop |=> $stable(count));

endmodule

// File: rtl/rmt_map_array.sv
module rmt_map_array #(
   parameter int NUM_ARCH = 8,
   parameter int TAG_W    = 4,
   localparam int AW = $clog2(NUM_ARCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    lk_idx,
   output logic [TAG_W-1:0] lk_tag,
   input  logic [AW-1:0]    rn_idx,
   output logic [TAG_W-1:0] rn_cur_tag,
   input  logic             rn_we,
   input  logic [TAG_W-1:0] rn_tag,
   input  logic             set_we,
   input  logic [AW-1:0]    set_idx,
   input  logic [TAG_W-1:0] set_tag
);

   logic [TAG_W-1:0] tbl [NUM_ARCH];

   for (genvar i = 0; i < NUM_ARCH; i++) begin : g_entry
      logic hit_set, hit_rn;
      assign hit_set = set_we && (set_idx == AW'(i));
      assign hit_rn  = rn_we  && (rn_idx  == AW'(i));
      // Squash rollback outranks a rename on the same entry
      always_ff @(posedge clk) begin
         if (!rst_n)       tbl[i] <= TAG_W'(i);
         else if (hit_set) tbl[i] <= set_tag;
         else if (hit_rn)  tbl[i] <= rn_tag;
      end
   end

   assign lk_tag     = tbl[lk_idx];
   assign rn_cur_tag = tbl[rn_idx];

   assert_rename_installs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_we && !(set_we && set_idx == rn_idx)) |=> (tbl[$past(rn_idx)] == $past(rn_tag)));

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> (tbl[$past(set_idx)] == $past(set_tag)));

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
   import rmt_pkg::*;
#(
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 16,
   parameter int ZERO_IDX = 0,
   parameter int IDX_W    = $clog2(NUM_ARCH) + 1,
   localparam int TAG_W = $clog2(NUM_PHYS),
   localparam int AW    = $clog2(NUM_ARCH),
   localparam int CNT_W = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [TAG_W-1:0] lk_tag,
   input  logic             rn_req,
   input  logic [IDX_W-1:0] rn_idx,
   output logic             rn_done,
   output logic             rn_stall,
   output logic [TAG_W-1:0] rn_new_tag,
   output logic [TAG_W-1:0] rn_old_tag,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [TAG_W-1:0] set_tag,
   output logic [CNT_W-1:0] free_count,
   output logic             idx_err
);

   // Elaboration-time parameter checks
   if (NUM_ARCH < 2)              $error("NUM_ARCH must be at least 2");
   if (NUM_PHYS <= NUM_ARCH + 1)  $error("NUM_PHYS must exceed NUM_ARCH by 2 or more");
   if (IDX_W < AW)                $error("IDX_W too narrow for NUM_ARCH");

   logic             lk_ok, rn_ok, set_ok, rn_is_zero, pop, fl_empty;
   logic [TAG_W-1:0] fl_head, map_lk_tag, map_rn_tag;
   rn_outcome_e      outcome;

   assign lk_ok  = ({1'b0, lk_idx}  < (IDX_W+1)'(NUM_ARCH));
   assign rn_ok  = ({1'b0, rn_idx}  < (IDX_W+1)'(NUM_ARCH));
   assign set_ok = ({1'b0, set_idx} < (IDX_W+1)'(NUM_ARCH));

   // Zero register variant chosen by parameter
   if (ZERO_IDX >= 0 && ZERO_IDX < NUM_ARCH) begin : g_zero
      assign rn_is_zero = (rn_idx == IDX_W'(ZERO_IDX));
   end else begin : g_nozero
      assign rn_is_zero = 1'b0;
   end

   always_comb begin
      outcome = RN_IDLE;
      if (rn_req) begin
         if (!rn_ok)          outcome = RN_ERR;
         else if (rn_is_zero) outcome = RN_ZERO;
         else if (fl_empty)   outcome = RN_STALL;
         else                 outcome = RN_DONE;
      end
   end

   assign pop = (outcome == RN_DONE);

   rmt_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
      .clk(clk), .rst_n(rst_n), .pop(pop),
      .head_tag(fl_head), .count(free_count), .empty(fl_empty)
   );

   rmt_map_array #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) u_map (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(lk_idx[AW-1:0]), .lk_tag(map_lk_tag),
      .rn_idx(rn_idx[AW-1:0]), .rn_cur_tag(map_rn_tag),
      .rn_we(pop), .rn_tag(fl_head),
      .set_we(set_en && set_ok), .set_idx(set_idx[AW-1:0]), .set_tag(set_tag)
   );

   assign lk_tag     = lk_ok ? map_lk_tag : '0;
   assign rn_done    = (outcome == RN_DONE) || (outcome == RN_ZERO);
   assign rn_stall   = (outcome == RN_STALL);
   assign rn_old_tag = rn_ok ? map_rn_tag : '0;
   assign rn_new_tag = (outcome == RN_ZERO) ? map_rn_tag : fl_head;
   assign idx_err    = !lk_ok || (rn_req && !rn_ok) || (set_en && !set_ok);

   assert_zero_no_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_req && rn_is_zero && rn_ok) |=> $stable(free_count));

   assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rn_stall |=> $stable(free_count));

   assert_err_no_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_req && !rn_ok) |=> $stable(free_count));

   assert_done_excl_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rn_done && rn_stall));

endmodule

// File: tb/rename_map_table_test.sv
module rename_map_table_test;

   localparam int NA = 8, NP = 16;

   logic       clk = 0, rst_n = 0;
   logic [3:0] lk_idx = 0, rn_idx = 0, set_idx = 0, set_tag = 0;
   logic       rn_req = 0, set_en = 0;
   logic [3:0] lk_tag, rn_new_tag, rn_old_tag, free_count;
   logic       rn_done, rn_stall, idx_err;

   logic [3:0] nz_lk_idx = 0, nz_rn_idx = 0;
   logic       nz_rn_req = 0;
   logic [3:0] nz_lk_tag, nz_new, nz_old, nz_count;
   logic       nz_done, nz_stall, nz_err;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   rename_map_table #(.NUM_ARCH(NA), .NUM_PHYS(NP), .ZERO_IDX(0)) uut (
      .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag),
      .rn_req(rn_req), .rn_idx(rn_idx), .rn_done(rn_done), .rn_stall(rn_stall),
      .rn_new_tag(rn_new_tag), .rn_old_tag(rn_old_tag),
      .set_en(set_en), .set_idx(set_idx), .set_tag(set_tag),
      .free_count(free_count), .idx_err(idx_err));

   rename_map_table #(.NUM_ARCH(NA), .NUM_PHYS(NP), .ZERO_IDX(NA)) uut_nz (
      .clk(clk), .rst_n(rst_n), .lk_idx(nz_lk_idx), .lk_tag(nz_lk_tag),
      .rn_req(nz_rn_req), .rn_idx(nz_rn_idx), .rn_done(nz_done), .rn_stall(nz_stall),
      .rn_new_tag(nz_new), .rn_old_tag(nz_old),
      .set_en(1'b0), .set_idx(4'd0), .set_tag(4'd0),
      .free_count(nz_count), .idx_err(nz_err));

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic lk_expect(string req, int idx, int exp);
      @(negedge clk); lk_idx = 4'(idx); #1;
      chk(req, lk_tag, exp);
   endtask

   // Issue one rename at the falling edge, check same-cycle outputs, release
   task automatic rename(string req, int idx, int done, int stall, int nt, int ot);
      @(negedge clk); rn_req = 1; rn_idx = 4'(idx); #1;
      chk({req, " done"}, rn_done, done);
      chk({req, " stall"}, rn_stall, stall);
      if (done != 0) begin
         chk({req, " new"}, rn_new_tag, nt);
         chk({req, " old"}, rn_old_tag, ot);
      end
      @(negedge clk); rn_req = 0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < NA; i++) lk_expect("R1 reset map", i, i);
      chk("R1 free count", free_count, NP - NA);
      chk("R1 no error", idx_err, 0);
   endtask

   task automatic t_rename_basic;
      rename("R2 first", 3, 1, 0, 8, 3);
      lk_expect("R2 installed", 3, 8);
      chk("R2 count", free_count, 7);
      rename("R2 second", 3, 1, 0, 9, 8);
      lk_expect("R2 installed again", 3, 9);
      chk("R2 count", free_count, 6);
   endtask

   task automatic t_same_cycle;
      @(negedge clk); lk_idx = 5; rn_req = 1; rn_idx = 5; #1;
      chk("R6 lookup sees old", lk_tag, 5);
      chk("R6 new tag", rn_new_tag, 10);
      @(negedge clk); rn_req = 0; #1;
      chk("R6 lookup sees new", lk_tag, 10);
   endtask

   task automatic t_zero;
      rename("R3 zero", 0, 1, 0, 0, 0);
      chk("R3 count unchanged", free_count, 5);
      lk_expect("R3 map unchanged", 0, 0);
   endtask

   task automatic t_set;
      @(negedge clk); set_en = 1; set_idx = 3; set_tag = 3;
      @(negedge clk); set_en = 0;
      lk_expect("R5 restored", 3, 3);
      chk("R5 count unchanged", free_count, 5);
   endtask

   task automatic t_set_vs_rename;
      @(negedge clk); set_en = 1; set_idx = 6; set_tag = 2; rn_req = 1; rn_idx = 6; #1;
      chk("R9 rename new", rn_new_tag, 11);
      chk("R9 rename old", rn_old_tag, 6);
      @(negedge clk); set_en = 0; rn_req = 0;
      lk_expect("R9 set wins", 6, 2);
      chk("R9 count popped", free_count, 4);
   endtask

   task automatic t_err;
      @(negedge clk); lk_idx = 9; #1;
      chk("R8 lookup err", idx_err, 1);
      chk("R8 lookup zero", lk_tag, 0);
      lk_idx = 1;
      rename("R8 rename oob", 12, 0, 0, 0, 0);
      chk("R8 count unchanged", free_count, 4);
      @(negedge clk); set_en = 1; set_idx = 15; set_tag = 7; #1;
      chk("R8 set err", idx_err, 1);
      @(negedge clk); set_en = 0; #1;
      chk("R8 err cleared", idx_err, 0);
      lk_expect("R8 entry 7 intact", 7, 7);
   endtask

   task automatic t_drain;
      rename("R2 drain a", 1, 1, 0, 12, 1);
      rename("R2 drain b", 2, 1, 0, 13, 2);
      rename("R2 drain c", 4, 1, 0, 14, 4);
      rename("R2 drain d", 7, 1, 0, 15, 7);
      chk("R7 empty", free_count, 0);
      rename("R7 stall", 2, 0, 1, 0, 0);
      lk_expect("R7 map unchanged", 2, 13);
      chk("R7 count stays 0", free_count, 0);
   endtask

   task automatic t_nozero;
      @(negedge clk); nz_rn_req = 1; nz_rn_idx = 0; #1;
      chk("R4 index 0 renames", nz_done, 1);
      chk("R4 new tag", nz_new, 8);
      @(negedge clk); nz_rn_req = 0; nz_lk_idx = 0; #1;
      chk("R4 installed", nz_lk_tag, 8);
      chk("R4 count", nz_count, 7);
   endtask

   bit finished = 0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_rename_basic();
      t_same_cycle();
      t_zero();
      t_set();
      t_set_vs_rename();
      t_err();
      t_drain();
      t_nozero();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule